// File: doc/BRIEF.md
# Double-Buffered Raster Frame Output

This block sits between a pixel compute engine and a 240-line low-rate video output. It keeps two frame stores of iteration values. The compute side fills the hidden store at its own pace. A raster scanner reads the visible store in step with the horizontal and vertical timing that the block generates itself. When the compute side reports a finished frame, the two stores trade roles, but only at the moment the scan enters vertical blanking. A picture is therefore never shown half old and half new.

Each store holds one full line stride per line. The stride is sized for the wide mode, and the narrow mode uses the same stride. In narrow mode the scanner shows each stored column for two clocks, so the line period and sync positions stay the same in both modes and only the address decode changes. The mode input is taken at the same vertical-blanking boundary as the buffer exchange. The defaults are a reduced geometry (64-column stride, 8 active lines, 80×12 total) so that the block elaborates quickly. At full size the parameters are a 640 stride and 240 lines, with totals chosen for about a 15.6 kHz line rate and a 59.7 Hz frame rate.

Top module: `dbl_frame_out`

## Requirements
- R1: While rst_ni is low, hsync_o, vsync_o, hblank_o, vblank_o and pix_o are all 0. Store 0 is visible and no exchange is pending.
- R2: A line lasts H_ACT+H_FP+H_SYNC+H_BP clocks. hblank_o is 1 for line positions H_ACT and above. hsync_o is an active-high pulse that covers positions H_ACT+H_FP up to, but not including, H_ACT+H_FP+H_SYNC.
- R3: A frame lasts V_ACT+V_FP+V_SYNC+V_BP lines. vblank_o is 1 on lines V_ACT and above. vsync_o is an active-high pulse on lines V_ACT+V_FP up to, but not including, V_ACT+V_FP+V_SYNC.
- R4: In wide mode (wide_i=1), pix_o at line l and position c < H_ACT equals the visible store's entry at address l*H_ACT+c. The value is in the same output cycle as the matching timing flags, and pix_o is 0 whenever either blank flag is set.
- R5: In narrow mode (wide_i=0), pix_o at line l and position c < H_ACT equals the visible store's entry at address l*H_ACT+c/2 (integer division). Each stored column is held for two clocks, and the line timing is unchanged.
- R6: wide_i is sampled only on the clock edge where the scan enters vertical blanking. A change during the active area first takes effect in the following frame.
- R7: A write with wr_en_i=1 stores wr_data_i at wr_addr_i in the hidden store only. It is not visible until an exchange.
- R8: A frame_done_i pulse arms an exchange that occurs on the next entry into vertical blanking, never during the active area.
- R9: If no frame_done_i pulse arrived since the last exchange, the stores keep their roles and the previous picture is shown again.
- R10: Several frame_done_i pulses before one vertical-blanking entry cause a single exchange.
- R11: The armed request clears when the exchange happens. A frame_done_i pulse on that same edge arms a new exchange for the next blanking entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the hidden store |
| wr_addr_i | input | AW | Write address, line*H_ACT + column |
| wr_data_i | input | ITER_W | Iteration value to store |
| frame_done_i | input | 1 | One-clock pulse: hidden frame is complete |
| wide_i | input | 1 | 1 = wide mode, 0 = narrow mode |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| hblank_o | output | 1 | Horizontal blanking |
| vblank_o | output | 1 | Vertical blanking |
| pix_o | output | ITER_W | Iteration value at the current scan position |

## Verification
The main function is run through a series of whole frames. Each frame uses a different seed-derived image and a different combination of mode and completion pulses: one pulse, none, two, and a mode change without a pulse. This separates a proper exchange from a missed exchange, a double toggle, and a mode switch that is tied to the buffer exchange. Every clock of each scanned frame is compared, so errors in sync placement, blank extent, address stride and narrow-mode column doubling all show up as mismatches. Directed runs then pulse completion and flip the mode in the middle of a visible frame to expose tearing. A final run places a pulse exactly on the blanking-entry edge while an exchange is already armed, which shows whether the request is re-armed or lost.

// File: rtl/fb_pkg.sv
package fb_pkg;
  typedef struct packed {
    logic hsync;
    logic vsync;
    logic hblank;
    logic vblank;
  } raster_t;
endpackage

// File: rtl/raster_gen.sv
module raster_gen
  import fb_pkg::*;
#(
  parameter int H_ACT  = 64,
  parameter int H_FP   = 4,
  parameter int H_SYNC = 8,
  parameter int H_BP   = 4,
  parameter int V_ACT  = 8,
  parameter int V_FP   = 1,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 1,
  localparam int H_TOTAL = H_ACT + H_FP + H_SYNC + H_BP,
  localparam int V_TOTAL = V_ACT + V_FP + V_SYNC + V_BP,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(V_TOTAL)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [HW-1:0] hcnt_o,
  output logic [VW-1:0] vcnt_o,
  output raster_t       tim_o,
  output logic          active_o,
  output logic          vb_entry_o
);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [HW-1:0] H_BLK  = HW'(H_ACT);
  localparam logic [HW-1:0] H_SS   = HW'(H_ACT + H_FP);
  localparam logic [HW-1:0] H_SE   = HW'(H_ACT + H_FP + H_SYNC);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);
  localparam logic [VW-1:0] V_BLK  = VW'(V_ACT);
  localparam logic [VW-1:0] V_ALST = VW'(V_ACT - 1);
  localparam logic [VW-1:0] V_SS   = VW'(V_ACT + V_FP);
  localparam logic [VW-1:0] V_SE   = VW'(V_ACT + V_FP + V_SYNC);

  logic [HW-1:0] hcnt_q;
  logic [VW-1:0] vcnt_q;
  logic          h_wrap;

  assign h_wrap = (hcnt_q == H_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q <= '0;
      vcnt_q <= '0;
    end else begin
      hcnt_q <= h_wrap ? '0 : hcnt_q + 1'b1;
      if (h_wrap) vcnt_q <= (vcnt_q == V_LAST) ? '0 : vcnt_q + 1'b1;
    end
  end

  always_comb begin
    tim_o.hblank = (hcnt_q >= H_BLK);
    tim_o.vblank = (vcnt_q >= V_BLK);
    tim_o.hsync  = (hcnt_q >= H_SS) && (hcnt_q < H_SE);
    tim_o.vsync  = (vcnt_q >= V_SS) && (vcnt_q < V_SE);
    active_o     = !tim_o.hblank && !tim_o.vblank;
    // last clock of last active line: next edge enters vblank
    vb_entry_o   = h_wrap && (vcnt_q == V_ALST);
  end

  assign hcnt_o = hcnt_q;
  assign vcnt_o = vcnt_q;

  p_hcnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hcnt_q <= H_LAST);
  p_vcnt_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(vcnt_q) |-> (hcnt_q == '0));
endmodule

// File: rtl/swap_ctrl.sv
module swap_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vb_entry_i,
  input  logic done_i,
  input  logic wide_i,
  output logic front_o,
  output logic wide_o
);
  logic front_q, pend_q, wide_q;
  logic do_swap;

  assign do_swap = vb_entry_i && pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      front_q <= 1'b0;
      pend_q  <= 1'b0;
      wide_q  <= 1'b1;
    end else begin
      if (do_swap) front_q <= ~front_q;
      // a pulse on the swap edge re-arms for the next blanking entry
      if (done_i)       pend_q <= 1'b1;
      else if (do_swap) pend_q <= 1'b0;
      if (vb_entry_i) wide_q <= wide_i;
    end
  end

  assign front_o = front_q;
  assign wide_o  = wide_q;

  p_swap_at_entry_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(front_q) |-> $past(vb_entry_i));
  p_no_swap_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vb_entry_i && !pend_q) |=> $stable(front_q));
  p_pend_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vb_entry_i && pend_q && !done_i) |=> !pend_q);
  p_rearm_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> pend_q);
  p_mode_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wide_q) |-> $past(vb_entry_i));
endmodule

// File: rtl/frame_bank.sv
module frame_bank #(
  parameter int DW    = 12,
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [DW-1:0] wd_i,
  input  logic [AW-1:0] ra_i,
  output logic [DW-1:0] rd_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wa_i] <= wd_i;
    rd_q <= mem_q[ra_i];
  end

  assign rd_o = rd_q;
endmodule

// File: rtl/dbl_frame_out.sv
module dbl_frame_out
  import fb_pkg::*;
#(
  parameter int ITER_W = 12,
  parameter int H_ACT  = 64,
  parameter int H_FP   = 4,
  parameter int H_SYNC = 8,
  parameter int H_BP   = 4,
  parameter int V_ACT  = 8,
  parameter int V_FP   = 1,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 1,
  localparam int DEPTH   = H_ACT * V_ACT,
  localparam int AW      = $clog2(DEPTH),
  localparam int H_TOTAL = H_ACT + H_FP + H_SYNC + H_BP,
  localparam int V_TOTAL = V_ACT + V_FP + V_SYNC + V_BP,
  localparam int HW      = $clog2(H_TOTAL),
  localparam int VW      = $clog2(V_TOTAL)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [ITER_W-1:0] wr_data_i,
  input  logic              frame_done_i,
  input  logic              wide_i,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              hblank_o,
  output logic              vblank_o,
  output logic [ITER_W-1:0] pix_o
);
  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  raster_t       tim, tim_q;
  logic          active, act_q;
  logic          vb_entry;
  logic          front, sel_q, wide_cur;
  logic [HW-1:0] col;
  logic [AW-1:0] rd_addr;
  logic [ITER_W-1:0] rd_data [2];

  raster_gen #(
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) u_raster (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hcnt_o    (hcnt),
    .vcnt_o    (vcnt),
    .tim_o     (tim),
    .active_o  (active),
    .vb_entry_o(vb_entry)
  );

  swap_ctrl u_swap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vb_entry_i(vb_entry),
    .done_i    (frame_done_i),
    .wide_i    (wide_i),
    .front_o   (front),
    .wide_o    (wide_cur)
  );

  // narrow mode repeats each stored column for two clocks
  always_comb begin
    col     = wide_cur ? hcnt : (hcnt >> 1);
    rd_addr = active ? (AW'(vcnt) * AW'(H_ACT) + AW'(col)) : '0;
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    frame_bank #(.DW(ITER_W), .DEPTH(DEPTH)) u_bank (
      .clk_i(clk_i),
      .we_i (wr_en_i && (front != 1'(b))),
      .wa_i (wr_addr_i),
      .wd_i (wr_data_i),
      .ra_i (rd_addr),
      .rd_o (rd_data[b])
    );
  end

  // timing delayed one clock to line up with the store read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tim_q <= '0;
      act_q <= 1'b0;
      sel_q <= 1'b0;
    end else begin
      tim_q <= tim;
      act_q <= active;
      sel_q <= front;
    end
  end

  assign hsync_o  = tim_q.hsync;
  assign vsync_o  = tim_q.vsync;
  assign hblank_o = tim_q.hblank;
  assign vblank_o = tim_q.vblank;
  assign pix_o    = act_q ? rd_data[sel_q] : '0;

  p_hsync_in_blank_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hsync_o |-> hblank_o);
  p_vsync_in_blank_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsync_o |-> vblank_o);
  p_sel_stable_active_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vblank_o |-> $stable(sel_q));
endmodule

// File: tb/tb_dbl_frame_out.sv
module tb_dbl_frame_out;
  localparam int HT = 80;
  localparam int VT = 12;
  localparam int HA = 64;
  localparam int VA = 8;
  localparam int NV = 6;
  localparam int V_SEED [NV] = '{1, 2, 3, 4, 5, 6};
  localparam int V_DONE [NV] = '{1, 0, 1, 2, 0, 1};
  localparam int V_WIDE [NV] = '{1, 1, 0, 0, 1, 1};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en = 1'b0;
  logic [8:0] wr_addr = '0;
  logic [11:0] wr_data = '0;
  logic done = 1'b0;
  logic wide = 1'b1;
  logic hsync, vsync, hblank, vblank;
  logic [11:0] pix;
  int n_chk = 0;
  int n_fail = 0;
  int shown_seed = 0;
  int shown_wide = 1;

  always #5 clk = ~clk;

  dbl_frame_out dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .frame_done_i(done), .wide_i(wide),
    .hsync_o(hsync), .vsync_o(vsync), .hblank_o(hblank), .vblank_o(vblank),
    .pix_o(pix)
  );

  function automatic logic [11:0] pat(int seed, int a);
    return 12'((seed * 397 + a * 5 + (a >> 3) * 11) & 12'hfff);
  endfunction

  task automatic fill(int seed);
    for (int a = 0; a < HA * VA; a++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 9'(a); wr_data = pat(seed, a);
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
  endtask

  task automatic wait_frame();
    logic last;
    last = vblank;
    forever begin
      @(negedge clk);
      if (last && !vblank) break;
      last = vblank;
    end
  endtask

  // scans one full frame from its first sample
  task automatic scan(int seed, int wm, string tag);
    for (int v = 0; v < VT; v++) begin
      for (int h = 0; h < HT; h++) begin
        logic e_hb, e_vb, e_hs, e_vs;
        logic [11:0] e_px;
        int x;
        e_hb = (h >= HA);
        e_vb = (v >= VA);
        e_hs = (h >= 68) && (h < 76);
        e_vs = (v >= 9) && (v < 11);
        x = wm ? h : h / 2;
        e_px = (!e_hb && !e_vb) ? pat(seed, v * HA + x) : 12'h0;
        n_chk++;
        if (hblank !== e_hb || vblank !== e_vb || hsync !== e_hs ||
            vsync !== e_vs || pix !== e_px) begin
          n_fail++;
          $display("FAIL %s line %0d pos %0d: hb/vb/hs/vs/pix act %b%b%b%b %h exp %b%b%b%b %h",
                   tag, v, h, hblank, vblank, hsync, vsync, pix,
                   e_hb, e_vb, e_hs, e_vs, e_px);
        end
        @(negedge clk);
      end
    end
  endtask

  task automatic check_frame(int seed, int wm, string tag);
    wait_frame();
    scan(seed, wm, tag);
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: run did not complete, act timeout exp finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    n_chk++;
    if ({hsync, vsync, hblank, vblank, pix} !== 16'h0) begin
      n_fail++;
      $display("FAIL R1 reset outputs act %b%b%b%b %h exp 0000 000",
               hsync, vsync, hblank, vblank, pix);
    end
    rst_ni = 1'b1;
    @(negedge clk);
    n_chk++;
    if ({hsync, vsync, hblank, vblank} !== 4'h0) begin
      n_fail++;
      $display("FAIL R1 first position flags act %b%b%b%b exp 0000",
               hsync, vsync, hblank, vblank);
    end

    // table: R2 R3 R4 R5 R6 R7 R9 R10
    for (int i = 0; i < NV; i++) begin
      fill(V_SEED[i]);
      for (int d = 0; d < V_DONE[i]; d++) pulse_done();
      @(negedge clk);
      wide = V_WIDE[i][0];
      if (V_DONE[i] > 0) shown_seed = V_SEED[i];
      shown_wide = V_WIDE[i];
      check_frame(shown_seed, shown_wide, $sformatf("R4/R5/R9/R10 vec%0d", i));
    end

    // R8 R6: pulse and mode flip mid-frame must not tear
    fill(7);
    wait_frame();
    fork
      scan(6, 1, "R8/R6 mid-frame");
      begin
        repeat (200) @(negedge clk);
        done = 1'b1; wide = 1'b0;
        @(negedge clk);
        done = 1'b0;
      end
    join
    check_frame(7, 0, "R8/R6 next frame");

    // R11: pulse on the exchange edge while armed
    fill(8);
    wait_frame();
    done = 1'b1;
    @(negedge clk); done = 1'b0;
    repeat (637) @(negedge clk);
    done = 1'b1;
    @(negedge clk); done = 1'b0;
    check_frame(8, 0, "R11 first exchange");
    check_frame(7, 0, "R11 re-armed exchange");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule